// File: doc/BRIEF.md
# Double-Buffered Subset-Sum Coefficient Table Updater

This block sits beside a bit-serial, memory-based FIR datapath. The datapath forms its products by lookup: each bit-slice of its input samples makes a table address, and the table returns a precomputed sum of coefficients. The block keeps two copies of that table in one dual-bank storage array. The filter always reads the active copy. Meanwhile a new coefficient set is expanded into the other copy, one entry per clock, and the filter keeps working throughout.

A new set arrives as a single strobe that carries all coefficients packed side by side. A fill state machine has two states, FILL_IDLE and FILL_RUN. A strobe taken in FILL_IDLE moves it to FILL_RUN. The last table address returns it to FILL_IDLE. A swap state machine has two states, SWAP_NONE and SWAP_HELD. A swap request moves it to SWAP_HELD. It leaves SWAP_HELD, flipping the bank bit, on the first clock in which the fill machine is in FILL_IDLE and the filter marks a word boundary. The bank change is one clock and a single address bit, so the filter never stalls.

Top module: `coef_table_updater`

## Requirements
- R1: After reset, `bank_sel` is 0, `busy` is 0, and every entry of both table copies reads as zero.
- R2: Table entry at address a is the signed sum of coefficient i for every bit i set in a. Coefficient i is `coef_in[i*CW +: CW]`, two's complement. The entry is sign-extended to CW+2 bits, so that sums of extreme coefficients stay exact. Entry 0 is zero.
- R3: A `coef_valid` strobe seen while `busy` is low starts a fill. `busy` is high from the next cycle for exactly 16 cycles, during which entries 0 to 15 are written in address order into the copy not selected by `bank_sel`.
- R4: While a fill runs, reads return the unchanged contents of the active copy.
- R5: A `coef_valid` strobe seen while `busy` is high is ignored. The table then holds the set that started the fill.
- R6: A swap request sets a pending swap. `bank_sel` toggles at the end of the first later cycle in which `word_edge` is high and no fill runs. A request and `word_edge` in the same cycle do not flip the bank in that cycle.
- R7: A swap requested during a fill is held. `bank_sel` stays unchanged until the fill ends and a later `word_edge` arrives, then it toggles once.
- R8: `rd_data` is registered. It shows the entry at {`bank_sel`, `rd_addr`} from the preceding clock edge and does not change between edges.
- R9: Several requests before a boundary merge into one toggle. `word_edge` with no pending request leaves `bank_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_valid | input | 1 | Strobe: new coefficient set on `coef_in` |
| coef_in | input | NCOEF*CW | Packed coefficients, coefficient i at bits i*CW upward |
| swap_req | input | 1 | Request to make the freshly built copy active |
| word_edge | input | 1 | Filter word boundary marker |
| rd_addr | input | NCOEF | Bit-slice lookup address from the filter |
| rd_data | output | CW+clog2(NCOEF) | Registered table entry from the active copy |
| bank_sel | output | 1 | Active copy currently served to the filter |
| busy | output | 1 | High while a new table is being written |

## Verification
The bench builds the block with its default parameters: four coefficients of 16 bits. That gives 16-entry tables, so every address of every rebuilt table is read back and compared after each swap. With 16-bit coefficients, directed sets of all-maximum and all-minimum values reach both ends of the 18-bit entry range and exercise the two guard bits. Random sets, some with a stray strobe in mid-fill, cover ordinary sign mixes. Directed sequences place swap requests and word boundaries before, during and after a fill.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    typedef enum logic {
        FILL_IDLE,
        FILL_RUN
    } fill_state_t;

    typedef enum logic {
        SWAP_NONE,
        SWAP_HELD
    } swap_state_t;

endpackage

// File: rtl/ctu_subset_sum.sv
module ctu_subset_sum #(
    parameter int NCOEF = 4,
    parameter int CW    = 16,
    parameter int EW    = CW + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NCOEF*CW-1:0]   coef_in,
    input  logic [NCOEF-1:0]      idx,
    output logic [EW-1:0]         sum
);

    localparam int XW = EW - CW;

    logic [CW-1:0] c_q  [NCOEF];
    logic [EW-1:0] term [NCOEF];

    // Captured coefficient set, held for the whole fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOEF; i++) c_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < NCOEF; i++) c_q[i] <= coef_in[i*CW +: CW];
        end
    end

    // One masked, sign-extended term per coefficient
    generate
        for (genvar i = 0; i < NCOEF; i++) begin : g_term
            assign term[i] = idx[i] ? {{XW{c_q[i][CW-1]}}, c_q[i]} : '0;
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int i = 0; i < NCOEF; i++) sum = sum + term[i];
    end

endmodule

// File: rtl/ctu_bank_ram.sv
module ctu_bank_ram #(
    parameter int AW = 4,
    parameter int EW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [EW-1:0] mem [2*DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2*DEPTH; k++) mem[k] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[{wbank, waddr}] <= wdata;
            rdata <= mem[{rbank, raddr}];
        end
    end

    // R4
    wr_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wbank != rbank));

endmodule

// File: rtl/ctu_ctrl.sv
module ctu_ctrl
    import ctu_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_valid,
    input  logic          swap_req,
    input  logic          word_edge,
    output logic          load_now,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          bank_sel,
    output logic          busy
);

    localparam logic [AW-1:0] LAST = '1;

    fill_state_t   fill_q, fill_d;
    swap_state_t   swap_q, swap_d;
    logic [AW-1:0] idx_q;
    logic          bank_q;
    logic          fire;

    // Next-state logic of both machines
    always_comb begin
        fill_d = fill_q;
        swap_d = swap_q;
        fire   = 1'b0;
        unique case (fill_q)
            FILL_IDLE: if (coef_valid) fill_d = FILL_RUN;
            FILL_RUN:  if (idx_q == LAST) fill_d = FILL_IDLE;
            default:   fill_d = FILL_IDLE;
        endcase
        unique case (swap_q)
            SWAP_NONE: if (swap_req) swap_d = SWAP_HELD;
            SWAP_HELD: if (fill_q == FILL_IDLE && word_edge) begin
                swap_d = SWAP_NONE;
                fire   = 1'b1;
            end
            default:   swap_d = SWAP_NONE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= FILL_IDLE;
            swap_q <= SWAP_NONE;
            idx_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            fill_q <= fill_d;
            swap_q <= swap_d;
            idx_q  <= (fill_q == FILL_RUN) ? idx_q + 1'b1 : '0;
            bank_q <= bank_q ^ fire;
        end
    end

    // Outputs
    always_comb begin
        busy     = (fill_q == FILL_RUN);
        wr_en    = busy;
        wr_addr  = idx_q;
        load_now = (fill_q == FILL_IDLE) && coef_valid;
        bank_sel = bank_q;
    end

    // R3
    fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx_q == LAST) |=> !busy);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(coef_valid));

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank_sel));

    // R9
    flip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_sel) |-> $past(word_edge));

endmodule

// File: rtl/coef_table_updater.sv
module coef_table_updater #(
    parameter int NCOEF = 4,
    parameter int CW    = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           coef_valid,
    input  logic [NCOEF*CW-1:0]            coef_in,
    input  logic                           swap_req,
    input  logic                           word_edge,
    input  logic [NCOEF-1:0]               rd_addr,
    output logic [CW+$clog2(NCOEF)-1:0]    rd_data,
    output logic                           bank_sel,
    output logic                           busy
);

    localparam int EW = CW + $clog2(NCOEF);

    logic             load_now;
    logic             wr_en;
    logic [NCOEF-1:0] wr_addr;
    logic [EW-1:0]    wr_data;

    ctu_ctrl #(.AW(NCOEF)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_valid (coef_valid),
        .swap_req   (swap_req),
        .word_edge  (word_edge),
        .load_now   (load_now),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .bank_sel   (bank_sel),
        .busy       (busy)
    );

    ctu_subset_sum #(.NCOEF(NCOEF), .CW(CW), .EW(EW)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_now),
        .coef_in (coef_in),
        .idx     (wr_addr),
        .sum     (wr_data)
    );

    ctu_bank_ram #(.AW(NCOEF), .EW(EW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wbank (~bank_sel),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rbank (bank_sel),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: tb/tb_coef_table_updater.sv
`timescale 1ns/1ps
module tb_coef_table_updater;

    localparam int NC = 4, CW = 16, EW = 18, DEPTH = 16, MAXCYC = 100000;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              coef_valid = 1'b0, swap_req = 1'b0, word_edge = 1'b0;
    logic [NC*CW-1:0]  coef_in = '0;
    logic [NC-1:0]     rd_addr = '0;
    logic [EW-1:0]     rd_data;
    logic              bank_sel, busy;

    int   errs = 0, checks = 0, cyc = 0;
    logic [EW-1:0] exp_tab [2][DEPTH];
    logic          exp_bank = 1'b0;

    coef_table_updater #(.NCOEF(NC), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_in(coef_in),
        .swap_req(swap_req), .word_edge(word_edge), .rd_addr(rd_addr),
        .rd_data(rd_data), .bank_sel(bank_sel), .busy(busy)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAXCYC) begin
            errs++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<%0d", cyc, MAXCYC);
            $display("Result: errors=%0d of %0d checks", errs, checks + 1);
            $finish;
        end
    end

    function automatic logic [EW-1:0] exp_entry(input logic [NC*CW-1:0] c, input int a);
        int s = 0;
        for (int i = 0; i < NC; i++)
            if (a[i]) s += int'($signed(c[i*CW +: CW]));
        return s[EW-1:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic verify_active(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 4'(a);
            step();
            chk(req, 32'(rd_data), 32'(exp_tab[exp_bank][a]), "table entry");
        end
    endtask

    task automatic do_swap();
        swap_req = 1'b1; word_edge = 1'b0;
        step();
        swap_req = 1'b0; word_edge = 1'b1;
        step();
        word_edge = 1'b0;
        exp_bank = ~exp_bank;
        chk("R6", 32'(bank_sel), 32'(exp_bank), "bank after swap");
    endtask

    task automatic load(input logic [NC*CW-1:0] c, input bit extra, input bit swap_mid, input bit edge_during);
        int n = 0;
        logic [NC-1:0] prev;
        coef_in = c; coef_valid = 1'b1;
        step();
        coef_valid = 1'b0;
        while (busy) begin
            n++;
            prev = 4'(n);
            rd_addr = prev;
            coef_valid = (extra && n == 5);          // R5 stray strobe
            if (extra && n == 5) coef_in = ~c;
            swap_req = (swap_mid && n == 3);
            word_edge = edge_during;
            step();
            chk("R4", 32'(rd_data), 32'(exp_tab[exp_bank][prev]), "active read during fill");
            if (swap_mid) chk("R7", 32'(bank_sel), 32'(exp_bank), "bank held during fill");
            if (n > 40) break;
        end
        coef_valid = 1'b0; swap_req = 1'b0; word_edge = 1'b0;
        chk("R3", 32'(n), 32'd16, "busy cycles");
        for (int a = 0; a < DEPTH; a++) exp_tab[~exp_bank][a] = exp_entry(c, a);
    endtask

    initial begin
        logic [EW-1:0] held;
        void'($urandom(32'd7321));
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++) exp_tab[b][a] = '0;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", 32'(bank_sel), 32'd0, "bank after reset");
        chk("R1", 32'(busy), 32'd0, "busy after reset");
        verify_active("R1");
        do_swap();
        verify_active("R1");
        do_swap();

        // R2 directed set
        load({16'd100, 16'd7, -16'sd5, 16'd3}, 1'b0, 1'b0, 1'b0);
        do_swap();
        verify_active("R2");

        // R2 extremes
        load({4{16'h7FFF}}, 1'b0, 1'b0, 1'b0);
        do_swap();
        verify_active("R2");
        load({4{16'h8000}}, 1'b0, 1'b0, 1'b0);
        do_swap();
        verify_active("R2");

        // R5 stray strobe ignored
        load({16'h1234, 16'hF00D, 16'h0042, 16'h8001}, 1'b1, 1'b0, 1'b0);
        do_swap();
        verify_active("R5");

        // R7 swap requested mid-fill, boundaries during fill
        load({16'd11, 16'd22, 16'd33, 16'd44}, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R7", 32'(bank_sel), 32'(exp_bank), "bank held until boundary");
        end
        word_edge = 1'b1;
        step();
        word_edge = 1'b0;
        exp_bank = ~exp_bank;
        chk("R7", 32'(bank_sel), 32'(exp_bank), "bank after held swap");
        verify_active("R7");

        // R6 request and boundary in the same cycle
        swap_req = 1'b1; word_edge = 1'b1;
        step();
        swap_req = 1'b0;
        chk("R6", 32'(bank_sel), 32'(exp_bank), "no flip with simultaneous edge");
        step();
        word_edge = 1'b0;
        exp_bank = ~exp_bank;
        chk("R6", 32'(bank_sel), 32'(exp_bank), "flip on later edge");

        // R9 merged requests, edge without request
        swap_req = 1'b1; step(); step(); swap_req = 1'b0; step();
        chk("R9", 32'(bank_sel), 32'(exp_bank), "no flip without edge");
        word_edge = 1'b1; step();
        exp_bank = ~exp_bank;
        chk("R9", 32'(bank_sel), 32'(exp_bank), "single flip");
        step(); word_edge = 1'b0;
        chk("R9", 32'(bank_sel), 32'(exp_bank), "edge without request");

        // R8 registered read
        rd_addr = 4'd5; step();
        held = rd_data;
        rd_addr = 4'd10; #1;
        chk("R8", 32'(rd_data), 32'(held), "stable between edges");
        step();
        chk("R8", 32'(rd_data), 32'(exp_tab[exp_bank][10]), "updated after edge");

        // R2 random sets
        for (int it = 0; it < 8; it++) begin
            logic [NC*CW-1:0] c;
            c = {$urandom(), $urandom()};
            load(c, (it % 3 == 0), 1'b0, 1'b0);
            do_swap();
            verify_active("R2");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule